// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This unit sequences a multi-register word transfer between a register file and memory. A single start request supplies four things: a base address, a 16-bit mask that selects registers, one of four addressing modes, and two flags, one for load/store direction and one for write-back. The sequencer then emits one word transfer per clock cycle. Each transfer carries a register index and a word address.

Selected registers go out in ascending index order, and addresses rise in steps of 4. The lowest-numbered register therefore always uses the lowest address in the window, whichever mode is chosen. The mode decides only where that window sits relative to the base and where the base ends up afterwards.

Stack-style operations map onto the same four modes:
- A full-descending push is decrement-before, and its pop is increment-after.
- An empty-ascending push is increment-after, and its pop is decrement-before.

The updated base value appears on the last transfer, so the surrounding core can write it back. Data movement, memory, faults and the register file are all outside this block.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, busy_o, xfer_valid_o, done_o and wb_valid_o are all low.
- R2: A start request accepted while idle is followed, on the next cycle, by the first transfer. Transfers then come one per cycle. The register indices are the selected bits of the mask in ascending order, and each address is the previous one plus 4.
- R3: The first (lowest) address depends on mode_i, where N is the number of selected registers: mode 0 (increment-after) gives base; mode 1 (increment-before) gives base+4; mode 2 (decrement-after) gives base-4N+4; mode 3 (decrement-before) gives base-4N.
- R4: The updated base is base+4N for modes 0 and 1, and base-4N for modes 2 and 3.
- R5: done_o is high for exactly one cycle, the cycle of the last transfer. busy_o is high from the cycle after acceptance through the done cycle, and low on the cycle after it.
- R6: With an empty mask, the block gives one busy cycle with done_o high and no transfer. The updated base equals the base.
- R7: A start request while busy_o is high is ignored. The running sequence continues unchanged.
- R8: wb_valid_o is high only in the done cycle, and only when write-back was requested. wb_base_o carries the updated base at that point.
- R9: xfer_load_o repeats the load flag captured at start on every transfer of the sequence.
- R10: Exactly N transfers occur. After the done cycle, xfer_valid_o stays low until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new sequence (taken only when idle) |
| base_i | input | 32 | Base address |
| mask_i | input | 16 | Register select mask, bit i selects register i |
| mode_i | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| load_i | input | 1 | 1 for load, 0 for store |
| wb_en_i | input | 1 | Request base write-back |
| busy_o | output | 1 | Sequence in progress |
| xfer_valid_o | output | 1 | A transfer is issued this cycle |
| xfer_reg_o | output | 4 | Register index of this transfer |
| xfer_addr_o | output | 32 | Word address of this transfer |
| xfer_load_o | output | 1 | Direction of this transfer |
| done_o | output | 1 | Last cycle of the sequence |
| wb_valid_o | output | 1 | Updated base is valid for write-back |
| wb_base_o | output | 32 | Updated base value |

## Verification
A corrupted remaining-mask register is visible within the same cycle. It shows up as a skipped or repeated register index, or as a done pulse that comes early or late. A wrong address register shows up on the very next transfer, as a first address that does not match the mode or as a step other than 4. The held write-back value can only be observed in the done cycle, so every write-back case is checked at that cycle. Start pulses during a running sequence check that nothing captured at start gets disturbed partway through.

// File: rtl/bt_pkg.sv
package bt_pkg;

    typedef enum logic [1:0] {
        BT_INC_AFTER  = 2'd0,
        BT_INC_BEFORE = 2'd1,
        BT_DEC_AFTER  = 2'd2,
        BT_DEC_BEFORE = 2'd3
    } bt_mode_e;

    // Direction bit: window lies below the base
    function automatic logic bt_is_desc(input bt_mode_e m);
        return m[1];
    endfunction

    // Step applied before the access rather than after it
    function automatic logic bt_is_before(input bt_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/bt_low_pick.sv
module bt_low_pick #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bt_count.sv
module bt_count #(
    parameter int N     = 16,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CNT_W'(vec[i]);
        end
    end
endmodule

// File: rtl/bt_bounds.sv
module bt_bounds
    import bt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  bt_mode_e          mode,
    output logic [ADDR_W-1:0] low_addr,
    output logic [ADDR_W-1:0] final_base
);
    localparam int SH = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] edge_addr;

    always_comb begin
        span       = ADDR_W'(cnt) << SH;
        final_base = bt_is_desc(mode) ? (base - span) : (base + span);
        // window bottom: base when ascending, base - span when descending
        edge_addr  = bt_is_desc(mode) ? (base - span) : base;
        // inc-before and dec-after both shift the window up one word
        low_addr   = (bt_is_before(mode) != bt_is_desc(mode)) ? (edge_addr + STEP) : edge_addr;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import bt_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG),
    localparam int CNT_W     = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [NREG-1:0]   mask_i,
    input  logic [1:0]        mode_i,
    input  logic              load_i,
    input  logic              wb_en_i,
    output logic              busy_o,
    output logic              xfer_valid_o,
    output logic [IDX_W-1:0]  xfer_reg_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic              xfer_load_o,
    output logic              done_o,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_base_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic              active_q;
    logic [NREG-1:0]   rem_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wb_q;
    logic              ld_q;
    logic              wben_q;

    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] low_addr;
    logic [ADDR_W-1:0] final_base;
    logic [IDX_W-1:0]  cur_idx;
    logic              cur_any;
    logic [NREG-1:0]   rem_next;
    logic              last;

    bt_count #(.N(NREG), .CNT_W(CNT_W)) u_count (
        .vec (mask_i),
        .cnt (sel_cnt)
    );

    bt_bounds #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES)) u_bounds (
        .base       (base_i),
        .cnt        (sel_cnt),
        .mode       (bt_mode_e'(mode_i)),
        .low_addr   (low_addr),
        .final_base (final_base)
    );

    bt_low_pick #(.N(NREG), .IDX_W(IDX_W)) u_pick (
        .vec (rem_q),
        .idx (cur_idx),
        .any (cur_any)
    );

    always_comb begin
        rem_next = rem_q & (rem_q - NREG'(1));
        last     = (rem_next == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rem_q    <= '0;
            addr_q   <= '0;
            wb_q     <= '0;
            ld_q     <= 1'b0;
            wben_q   <= 1'b0;
        end else if (active_q) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + STEP;
            if (last) begin
                active_q <= 1'b0;
            end
        end else if (start_i) begin
            active_q <= 1'b1;
            rem_q    <= mask_i;
            addr_q   <= low_addr;
            wb_q     <= final_base;
            ld_q     <= load_i;
            wben_q   <= wb_en_i;
        end
    end

    always_comb begin
        busy_o       = active_q;
        xfer_valid_o = active_q && cur_any;
        xfer_reg_o   = cur_idx;
        xfer_addr_o  = addr_q;
        xfer_load_o  = ld_q;
        done_o       = active_q && last;
        wb_valid_o   = active_q && last && wben_q;
        wb_base_o    = wb_q;
    end
endmodule

// File: rtl/bt_seq_chk.sv
module bt_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              xfer_valid_o,
    input logic [IDX_W-1:0]  xfer_reg_o,
    input logic [ADDR_W-1:0] xfer_addr_o,
    input logic              xfer_load_o,
    input logic              done_o,
    input logic              wb_valid_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    p_xfer_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o || done_o) |-> busy_o);

    p_done_then_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o && !xfer_valid_o));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !done_o) |=> (xfer_valid_o && xfer_addr_o == $past(xfer_addr_o) + STEP));

    p_reg_ascend_r2: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !done_o) |=> (xfer_reg_o > $past(xfer_reg_o)));

    p_wb_only_done_r8: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> done_o);

    p_load_held_r9: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid_o && !done_o) |=> $stable(xfer_load_o));

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind blk_xfer_seq bt_seq_chk #(
    .ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/tb_blk_xfer_seq.sv
module tb_blk_xfer_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [31:0] base_i;
    logic [15:0] mask_i;
    logic [1:0]  mode_i;
    logic        load_i;
    logic        wb_en_i;
    logic        busy_o;
    logic        xfer_valid_o;
    logic [3:0]  xfer_reg_o;
    logic [31:0] xfer_addr_o;
    logic        xfer_load_o;
    logic        done_o;
    logic        wb_valid_o;
    logic [31:0] wb_base_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_xfer_seq dut (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
        .mode_i(mode_i), .load_i(load_i), .wb_en_i(wb_en_i), .busy_o(busy_o),
        .xfer_valid_o(xfer_valid_o), .xfer_reg_o(xfer_reg_o), .xfer_addr_o(xfer_addr_o),
        .xfer_load_o(xfer_load_o), .done_o(done_o), .wb_valid_o(wb_valid_o),
        .wb_base_o(wb_base_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act cycles=%0d exp below %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic logic [31:0] exp_low(input logic [31:0] b, input logic [1:0] md, input int n);
        case (md)
            2'd0:    return b;
            2'd1:    return b + 32'd4;
            2'd2:    return b - 32'(4 * n) + 32'd4;
            default: return b - 32'(4 * n);
        endcase
    endfunction

    function automatic logic [31:0] exp_final(input logic [31:0] b, input logic [1:0] md, input int n);
        return md[1] ? (b - 32'(4 * n)) : (b + 32'(4 * n));
    endfunction

    task automatic run_seq(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                           input logic ld, input logic wb, input logic poke);
        int n;
        int k;
        logic [31:0] addr;
        n = popc(m);
        @(negedge clk);
        start_i = 1'b1; base_i = b; mask_i = m; mode_i = md; load_i = ld; wb_en_i = wb;
        @(negedge clk);
        if (poke) begin
            // R7: disturbing start while busy
            start_i = 1'b1; base_i = $urandom; mask_i = 16'(~m); mode_i = ~md;
            load_i = ~ld; wb_en_i = ~wb;
        end else begin
            start_i = 1'b0;
        end
        if (n == 0) begin
            chk(busy_o == 1'b1, "R6 busy", 32'(busy_o), 32'd1);
            chk(xfer_valid_o == 1'b0, "R6 no xfer", 32'(xfer_valid_o), 32'd0);
            chk(done_o == 1'b1, "R6 done", 32'(done_o), 32'd1);
            chk(wb_valid_o == wb, "R8 wb_valid empty", 32'(wb_valid_o), 32'(wb));
            if (wb) chk(wb_base_o == b, "R6 base unchanged", wb_base_o, b);
            @(negedge clk);
        end else begin
            addr = exp_low(b, md, n);
            k = 0;
            for (int i = 0; i < 16; i++) begin
                if (m[i]) begin
                    chk(xfer_valid_o == 1'b1, "R2 valid", 32'(xfer_valid_o), 32'd1);
                    chk(busy_o == 1'b1, "R5 busy", 32'(busy_o), 32'd1);
                    chk(xfer_reg_o == 4'(i), "R2 reg", 32'(xfer_reg_o), 32'(i));
                    chk(xfer_addr_o == addr, (k == 0) ? "R3 low addr" : "R2 addr", xfer_addr_o, addr);
                    chk(xfer_load_o == ld, "R9 load", 32'(xfer_load_o), 32'(ld));
                    chk(done_o == (k == n - 1), "R5 done", 32'(done_o), 32'(k == n - 1));
                    chk(wb_valid_o == (wb && k == n - 1), "R8 wb_valid", 32'(wb_valid_o), 32'(wb && k == n - 1));
                    if (k == n - 1 && wb)
                        chk(wb_base_o == exp_final(b, md, n), "R4 final base", wb_base_o, exp_final(b, md, n));
                    addr = addr + 32'd4;
                    k++;
                    @(negedge clk);
                end
            end
        end
        chk(busy_o == 1'b0, "R5 idle after done", 32'(busy_o), 32'd0);
        chk(xfer_valid_o == 1'b0, "R10 no extra xfer", 32'(xfer_valid_o), 32'd0);
        start_i = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; base_i = '0; mask_i = '0; mode_i = '0; load_i = 1'b0; wb_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0, "R1 busy", 32'(busy_o), 32'd0);
        chk(xfer_valid_o == 1'b0, "R1 valid", 32'(xfer_valid_o), 32'd0);
        chk(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
        chk(wb_valid_o == 1'b0, "R1 wb_valid", 32'(wb_valid_o), 32'd0);

        run_seq(32'h0000_1000, 16'h0025, 2'd0, 1'b1, 1'b1, 1'b0); // R3 inc-after
        run_seq(32'h0000_1000, 16'h0025, 2'd1, 1'b0, 1'b1, 1'b0); // R3 inc-before
        run_seq(32'h0000_1018, 16'h0023, 2'd2, 1'b0, 1'b1, 1'b0); // R3 dec-after
        run_seq(32'h0000_1018, 16'h0023, 2'd3, 1'b0, 1'b1, 1'b0); // R3 dec-before, stack push
        run_seq(32'h0000_2000, 16'hFFFF, 2'd3, 1'b0, 1'b1, 1'b0); // R4 full mask
        run_seq(32'h0000_0000, 16'h8000, 2'd2, 1'b1, 1'b1, 1'b0); // R4 wrap below zero
        run_seq(32'h0000_3000, 16'h0000, 2'd1, 1'b1, 1'b1, 1'b0); // R6 empty with wb
        run_seq(32'h0000_3000, 16'h0000, 2'd0, 1'b0, 1'b0, 1'b0); // R6 empty no wb
        run_seq(32'h0000_4000, 16'h0F0F, 2'd0, 1'b1, 1'b0, 1'b1); // R7 start ignored
        run_seq(32'h0000_5000, 16'h0001, 2'd3, 1'b1, 1'b1, 1'b1); // R7 single reg

        for (int t = 0; t < 60; t++) begin
            logic [31:0] rb;
            logic [15:0] rm;
            rb = $urandom & 32'hFFFF_FFFC;
            rm = 16'($urandom);
            if (t % 7 == 0) rm = 16'(1) << ($urandom % 16);
            run_seq(rb, rm, 2'($urandom), 1'($urandom), 1'($urandom), 1'(t % 3 == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule